// File: doc/BRIEF.md
# Self-Advancing Compare Square-Wave Channel

This block is one compare channel that hangs off a shared, free-running timebase counter whose width is twice the compare width. It holds a compare byte and an offset byte. Each time the timebase advances and its low half equals the compare byte, the channel flips its output pin and moves the compare byte forward by the offset. Toggles therefore come every `offset` timebase steps, with no reload of the counter, and the pin carries a square wave at the timebase rate divided by twice the offset.

Software programs the channel through a small write port with four targets: compare byte, offset byte, mode bits and flag clear. Writing the compare byte disarms the channel. Writing the offset byte arms it again, so a new phase and period can be loaded without a stray toggle in between. An optional flag marks the moment when the whole timebase equals the combined `{offset, compare}` value.

Top module: `freq_out_channel`

## Requirements
- R1: After reset the output pin is 0, the match flag is 0, the compare and offset bytes are 0, and all mode bits are clear.
- R2: On a cycle with `tb_tick` high, with the channel active and `tb_count[CW-1:0]` equal to the compare byte, the output pin toggles at the next clock edge. In every other case it holds.
- R3: Each such match adds the offset to the compare byte modulo 2^CW, so successive toggles are `offset` ticks apart.
- R4: An offset of 0 acts as 2^CW, giving 2^CW ticks between toggles.
- R5: Matches are evaluated only on cycles with `tb_tick` high. While the count is held between ticks, one match produces exactly one toggle.
- R6: A write with `wr_sel`=2 loads the mode bits from `wr_data[3:0]`: bit0 is compare enable, bit1 is toggle, bit2 is square-wave mode and bit3 is flag enable. The channel is active only when bits 0, 1 and 2 are all set.
- R7: A write with `wr_sel`=0 loads the compare byte and clears compare enable. A write with `wr_sel`=1 loads the offset byte and sets compare enable.
- R8: With flag enable set and the channel active, a tick on which the whole `tb_count` equals `{offset, compare}` sets `match_flag`. A match on the low half alone never sets it.
- R9: `match_flag` stays set until a write with `wr_sel`=3 and `wr_data[0]`=0 clears it. Such a write with `wr_data[0]`=1 has no effect. A hardware set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 compare, 1 offset, 2 mode, 3 flag |
| wr_data | input | CW | Write data |
| tb_count | input | 2*CW | Current timebase count |
| tb_tick | input | 1 | Timebase advances this cycle |
| wave_out | output | 1 | Square-wave output pin |
| match_flag | output | 1 | Full-width match flag |

## Verification
The bench builds the channel with CW=4, so the timebase is 8 bits wide and the compare byte is 4 bits wide. At that size every offset value, including the zero-means-maximum case, can be swept both with a tick on every cycle and with sparse ticks. Compare wrap-around happens within a few dozen ticks, and full-width flag matches occur within a single 256-count timebase period. This makes the set-versus-clear collision and the disarm-on-write behaviour cheap to reach.

// File: rtl/freq_out_channel.sv
module freq_out_channel #(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [CW-1:0]   wr_data,
  input  logic [2*CW-1:0] tb_count,
  input  logic            tb_tick,
  output logic            wave_out,
  output logic            match_flag
);
  localparam int TW = 2 * CW;

  logic [CW-1:0] cmp_lo, cmp_hi;
  logic cmp_en, tog_en, pwm_en, flag_en;

  wire active   = cmp_en & tog_en & pwm_en;
  wire lo_hit   = tb_tick & active & (tb_count[CW-1:0] == cmp_lo);
  wire full_hit = tb_tick & active & flag_en & (tb_count == TW'({cmp_hi, cmp_lo}));
  wire wr_lo    = wr_en & (wr_sel == 2'd0);
  wire wr_hi    = wr_en & (wr_sel == 2'd1);
  wire wr_mode  = wr_en & (wr_sel == 2'd2);
  wire wr_clr   = wr_en & (wr_sel == 2'd3) & ~wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_lo     <= '0;
      cmp_hi     <= '0;
      cmp_en     <= 1'b0;
      tog_en     <= 1'b0;
      pwm_en     <= 1'b0;
      flag_en    <= 1'b0;
      wave_out   <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      if (wr_lo)        cmp_lo <= wr_data;
      else if (lo_hit)  cmp_lo <= cmp_lo + cmp_hi;
      if (wr_hi)        cmp_hi <= wr_data;
      if (wr_mode)      {flag_en, pwm_en, tog_en, cmp_en} <= wr_data[3:0];
      else if (wr_lo)   cmp_en <= 1'b0;
      else if (wr_hi)   cmp_en <= 1'b1;
      if (lo_hit)       wave_out <= ~wave_out;
      if (full_hit)     match_flag <= 1'b1;
      else if (wr_clr)  match_flag <= 1'b0;
    end
  end
endmodule

module freq_out_channel_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [CW-1:0] wr_data,
  input logic          tb_tick,
  input logic          wave_out,
  input logic          match_flag,
  input logic          cmp_en,
  input logic          tog_en,
  input logic          pwm_en,
  input logic          flag_en
);
  a_r5_no_tick_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_tick |=> $stable(wave_out));

  a_r6_inactive_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_en && tog_en && pwm_en) |=> $stable(wave_out));

  a_r7_lo_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> !cmp_en);

  a_r7_hi_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> cmp_en);

  a_r8_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(flag_en && tb_tick));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !(wr_en && wr_sel == 2'd3 && !wr_data[0])) |=> match_flag);
endmodule

bind freq_out_channel freq_out_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .tb_tick(tb_tick), .wave_out(wave_out), .match_flag(match_flag),
  .cmp_en(cmp_en), .tog_en(tog_en), .pwm_en(pwm_en), .flag_en(flag_en)
);

// File: tb/freq_out_channel_bench.sv
module freq_out_channel_bench;
  localparam int CW = 4;
  localparam int TW = 2 * CW;
  localparam int M  = 1 << CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [CW-1:0] wr_data = '0;
  logic [TW-1:0] tb_count = '0;
  logic tb_tick = 1'b0;
  logic wave_out, match_flag;

  always #4 clk = ~clk;

  freq_out_channel #(.CW(CW)) u_freq_out_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tb_count(tb_count), .tb_tick(tb_tick), .wave_out(wave_out), .match_flag(match_flag)
  );

  int checks = 0, fails = 0;
  string req = "R1";
  logic [TW-1:0] cnt = '0;
  logic [CW-1:0] elo = '0, ehi = '0;
  logic [3:0] emode = '0;
  logic ewave = 1'b0, eflag = 1'b0;
  bit done = 0;

  function automatic bit act();
    return emode[0] & emode[1] & emode[2];
  endfunction

  function automatic bit full_next();
    return act() & emode[3] & (cnt == {ehi, elo});
  endfunction

  task automatic check_out();
    checks++;
    if (wave_out !== ewave || match_flag !== eflag) begin
      fails++;
      $display("FAIL %s t=%0t wave=%b flag=%b expected wave=%b flag=%b",
               req, $time, wave_out, match_flag, ewave, eflag);
    end
  endtask

  task automatic step(input bit tick, input bit we, input logic [1:0] sel, input logic [CW-1:0] d);
    bit setf;
    check_out();
    tb_tick = tick; tb_count = cnt;
    wr_en = we; wr_sel = sel; wr_data = d;
    setf = tick & full_next();
    if (tick && act() && cnt[CW-1:0] == elo) begin
      ewave = ~ewave;
      elo = elo + ehi;
    end
    if (we) begin
      case (sel)
        2'd0: begin elo = d; emode[0] = 1'b0; end
        2'd1: begin ehi = d; emode[0] = 1'b1; end
        2'd2: emode = d[3:0];
        default: if (!d[0]) eflag = 1'b0;
      endcase
    end
    if (setf) eflag = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tb_tick = 1'b0;
    if (tick) cnt = cnt + 1'b1;
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      for (int g = 1; g < gap; g++) step(1'b0, 1'b0, 2'd0, '0);
      step(1'b1, 1'b0, 2'd0, '0);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [CW-1:0] d);
    step(1'b0, 1'b1, sel, d);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R1";
    check_out();
    rst_n = 1'b1;
    @(negedge clk);
    run(20, 1);

    req = "R2 R3 R4 sweep";
    for (int h = 0; h < M; h++) begin
      wr(2'd2, CW'(4'b0111));
      wr(2'd0, CW'((h * 5) % M));
      wr(2'd1, CW'(h));
      run(3 * M, 1);
    end

    req = "R5 sparse ticks";
    for (int h = 0; h < M; h++) begin
      wr(2'd0, CW'((h * 3) % M));
      wr(2'd1, CW'(h));
      run(2 * M + 2, 3);
    end

    req = "R6 mode gating";
    for (int m = 0; m < 8; m++) begin
      wr(2'd2, CW'(m));
      wr(2'd0, CW'(2));
      wr(2'd2, CW'(m));
      wr(2'd1, CW'(3));
      wr(2'd2, CW'(m));
      run(2 * M, 1);
    end

    req = "R7 disarm";
    wr(2'd2, CW'(4'b0111));
    wr(2'd1, CW'(4));
    run(M, 1);
    wr(2'd0, CW'(1));
    run(2 * M, 1);
    wr(2'd1, CW'(4));
    run(2 * M, 1);

    req = "R8 full match";
    wr(2'd2, CW'(4'b0111));
    wr(2'd0, CW'(2));
    wr(2'd1, CW'(5));
    run(300, 1);
    wr(2'd2, CW'(4'b1111));
    run(300, 1);

    req = "R9 clear";
    wr(2'd3, CW'(1));
    run(2, 1);
    wr(2'd3, CW'(0));
    run(2, 1);
    wr(2'd3, CW'(1));
    run(2, 1);

    req = "R9 set wins";
    begin
      int k = 0;
      while (!full_next() && k < 2000) begin step(1'b1, 1'b0, 2'd0, '0); k++; end
      if (k >= 2000) begin
        fails++;
        $display("FAIL R9 no full match reached actual=none expected=match");
      end
      step(1'b1, 1'b1, 2'd3, CW'(0));
      checks++;
      if (match_flag !== 1'b1) begin
        fails++;
        $display("FAIL R9 set-wins flag=%b expected 1", match_flag);
      end
      run(4, 1);
    end

    check_out();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule